// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block paces auto-refresh for a four-bank DDR memory controller. A free-running interval counter, clocked by the controller clock, adds one refresh to an owed count each time a programmable refresh interval expires. While anything is owed, the block asks the command arbiter for a refresh. Permission to issue is given only while every bank reports precharged, and the arbiter confirms each issued refresh with an acknowledge. After each acknowledged refresh the block closes the command window for the refresh cycle time, then reports that the refresh is done.

Up to eight refreshes may be postponed. When the owed count reaches that limit, an urgent flag tells the arbiter to stop normal traffic and drain the backlog. The block also decides when self refresh may start, which requires idle banks and no refresh cycle in flight. While the device is in self refresh, the interval counter is frozen and the owed count is kept at zero. On wake-up, two recovery windows run from the same instant. The non-read window is set in nanoseconds. The read window is a fixed number of clocks. All times given in nanoseconds are converted to whole clock cycles, rounding up.

Top module: `dram_refresh_scheduler`

## Requirements
- R1: The owed count rises by one every TREFI_CYC clocks, where TREFI_CYC = ceil(TREFI_NS*1000/CLK_PS). The first increment lands on the TREFI_CYC-th rising edge after reset release. The count does not rise while the device is in self refresh.
- R2: `ref_req_o` is high exactly when the block is in normal operation, the owed count is non-zero and no refresh cycle window is open. `ref_ok_o` is `ref_req_o` qualified by `all_idle_i`.
- R3: An acknowledge is accepted only in a cycle where `ref_ok_o` is high. An accepted acknowledge lowers the owed count by one and raises `ref_done_o` for one cycle on the following clock. Any other acknowledge changes nothing.
- R4: The owed count saturates at OWED_MAX (default 8). `urgent_o` is high while the count equals OWED_MAX.
- R5: After an accepted acknowledge, `nonread_ok_o`, `read_ok_o` and `ref_req_o` are low for TRFC_CYC = ceil(TRFC_NS*1000/CLK_PS) cycles. Self-refresh entry is also blocked for that time.
- R6: Self refresh starts on the clock where `sr_enter_i` and `all_idle_i` are both high, the block is in normal operation, no refresh cycle window is open and no acknowledge is accepted. The owed count is cleared on that clock.
- R7: While `in_sr_o` is high, the interval position is frozen, the owed count stays zero and both command permissions are low.
- R8: In self refresh, `sr_exit_i` starts the wake-up. `nonread_ok_o` rises TXSNR_CYC clocks after that edge and `read_ok_o` rises TXSRD_CK clocks after it. Refresh requests resume one clock after the read window ends.
- R9: During reset the owed count is zero, `ref_req_o`, `urgent_o`, `ref_done_o` and `in_sr_o` are low, and both command permissions are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| all_idle_i | input | 1 | Every bank is precharged |
| ref_ack_i | input | 1 | Arbiter issued a refresh command this cycle |
| sr_enter_i | input | 1 | Request to enter self refresh (level) |
| sr_exit_i | input | 1 | Request to leave self refresh |
| ref_req_o | output | 1 | A refresh is owed and may be prepared |
| ref_ok_o | output | 1 | A refresh may be issued now |
| ref_done_o | output | 1 | One-cycle pulse after an accepted refresh |
| urgent_o | output | 1 | Backlog is full; normal traffic must yield |
| owed_o | output | $clog2(OWED_MAX+1) | Number of refreshes owed |
| in_sr_o | output | 1 | Device is in self refresh |
| nonread_ok_o | output | 1 | Non-read commands are allowed |
| read_ok_o | output | 1 | Read commands are allowed |

## Verification
The bench lets the backlog fill to its limit and lets one more interval pass. A counter that wrapped instead of saturating would drop to zero at that point and lower the urgent flag. It sends an acknowledge while nothing is owed, which a design without the permission gate would turn into a spurious done pulse or a count underflow. It holds the device in self refresh across several intervals and then times the next increment after wake-up: a counter that kept running in self refresh, or restarted from zero, would produce that increment on the wrong clock. It measures both wake-up windows and the refresh-cycle window to the exact clock. It also asks for self refresh while banks are open and again while a refresh cycle is in flight, and either request would enter too early if a gate were missing.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SELF = 2'd1,
    ST_WAKE = 2'd2
  } rfs_state_e;

  // Whole clock cycles covering a duration given in picoseconds, rounded up.
  function automatic int unsigned cyc_ceil(input int unsigned dur_ps,
                                           input int unsigned clk_ps);
    return (dur_ps + clk_ps - 1) / clk_ps;
  endfunction

  // Counter width able to hold values 0..max_val.
  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
  parameter int unsigned PERIOD = 1950,
  localparam int unsigned CW = rfs_pkg::width_for(PERIOD - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          tick,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assign tick = run && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (run) begin
      if (count == LAST) count <= '0;
      else               count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/rfs_owed.sv
module rfs_owed #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned OW = rfs_pkg::width_for(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] count
);

  localparam logic [OW-1:0] TOP = OW'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (count != TOP) count <= count + 1'b1;
        2'b01:   if (count != '0)  count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rfs_delay.sv
module rfs_delay #(
  parameter int unsigned SPAN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned NN = (SPAN < 1) ? 1 : SPAN;
  localparam int unsigned W  = rfs_pkg::width_for(NN);

  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= W'(NN);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/rfs_sr_fsm.sv
module rfs_sr_fsm
  import rfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_ok,
  input  logic       exit_req,
  input  logic       rd_busy,
  output rfs_state_e state,
  output logic       entry,
  output logic       wake
);

  rfs_state_e nxt;

  assign entry = (state == ST_RUN)  && enter_ok;
  assign wake  = (state == ST_SELF) && exit_req;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:  if (entry)    nxt = ST_SELF;
      ST_SELF: if (wake)     nxt = ST_WAKE;
      ST_WAKE: if (!rd_busy) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

endmodule

// File: rtl/dram_refresh_scheduler.sv
module dram_refresh_scheduler
  import rfs_pkg::*;
#(
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned TREFI_NS = 15600,
  parameter int unsigned TRFC_NS  = 75,
  parameter int unsigned TXSNR_NS = 75,
  parameter int unsigned TXSRD_CK = 200,
  parameter int unsigned OWED_MAX = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               all_idle_i,
  input  logic                               ref_ack_i,
  input  logic                               sr_enter_i,
  input  logic                               sr_exit_i,
  output logic                               ref_req_o,
  output logic                               ref_ok_o,
  output logic                               ref_done_o,
  output logic                               urgent_o,
  output logic [$clog2(OWED_MAX+1)-1:0]      owed_o,
  output logic                               in_sr_o,
  output logic                               nonread_ok_o,
  output logic                               read_ok_o
);

  localparam int unsigned TREFI_CYC = cyc_ceil(TREFI_NS * 1000, CLK_PS);
  localparam int unsigned TRFC_CYC  = cyc_ceil(TRFC_NS * 1000, CLK_PS);
  localparam int unsigned TXSNR_CYC = cyc_ceil(TXSNR_NS * 1000, CLK_PS);
  localparam int unsigned CW        = width_for(TREFI_CYC - 1);
  localparam int unsigned OW        = width_for(OWED_MAX);

  // Named internal events, observed by the bound checker.
  rfs_state_e    state;
  logic          iv_tick;
  logic [CW-1:0] iv_count;
  logic          ack_acc;
  logic          rfc_busy;
  logic          nr_busy;
  logic          rd_busy;
  logic          sr_entry;
  logic          sr_wake;
  logic          enter_ok;
  logic          in_run;
  logic [OW-1:0] owed;

  assign in_run = (state == ST_RUN);

  rfs_interval #(.PERIOD(TREFI_CYC)) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_SELF),
    .tick  (iv_tick),
    .count (iv_count)
  );

  rfs_owed #(.LIMIT(OWED_MAX)) u_owed (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sr_entry || (state == ST_SELF)),
    .inc   (iv_tick),
    .dec   (ack_acc),
    .count (owed)
  );

  assign ref_req_o = in_run && (owed != '0) && !rfc_busy;
  assign ref_ok_o  = ref_req_o && all_idle_i;
  assign ack_acc   = ref_ok_o && ref_ack_i;
  assign enter_ok  = in_run && sr_enter_i && all_idle_i && !rfc_busy && !ack_acc;

  rfs_delay #(.SPAN(TRFC_CYC)) u_rfc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ack_acc),
    .busy  (rfc_busy)
  );

  rfs_delay #(.SPAN(TXSNR_CYC)) u_xsnr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sr_wake),
    .busy  (nr_busy)
  );

  rfs_delay #(.SPAN(TXSRD_CK)) u_xsrd (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sr_wake),
    .busy  (rd_busy)
  );

  rfs_sr_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter_ok (enter_ok),
    .exit_req (sr_exit_i),
    .rd_busy  (rd_busy),
    .state    (state),
    .entry    (sr_entry),
    .wake     (sr_wake)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_done_o <= 1'b0;
    else        ref_done_o <= ack_acc;
  end

  assign owed_o       = owed;
  assign urgent_o     = (owed == OW'(OWED_MAX));
  assign in_sr_o      = (state == ST_SELF);
  assign nonread_ok_o = (state != ST_SELF) && !nr_busy && !rfc_busy;
  assign read_ok_o    = (state != ST_SELF) && !rd_busy && !rfc_busy;

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned OWED_MAX = 8,
  parameter int unsigned CW       = 1,
  localparam int unsigned OW      = rfs_pkg::width_for(OWED_MAX)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          all_idle_i,
  input logic          iv_tick,
  input logic [CW-1:0] iv_count,
  input logic          ack_acc,
  input logic          ref_req_o,
  input logic          ref_done_o,
  input logic [OW-1:0] owed_o,
  input logic          in_sr_o,
  input logic          nonread_ok_o,
  input logic          read_ok_o
);

  // R4
  owed_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_o == OW'(OWED_MAX)) && iv_tick && !ack_acc |=> owed_o == OW'(OWED_MAX));

  // R3
  ack_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_acc && !iv_tick |=> ref_done_o && (owed_o == $past(owed_o) - 1'b1));

  // R5
  rfc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_acc |=> !nonread_ok_o && !read_ok_o && !ref_req_o);

  // R7
  sr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr_o && $past(in_sr_o) |-> $stable(iv_count) && (owed_o == '0));

  // R7
  sr_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr_o |-> !nonread_ok_o && !read_ok_o && !ref_req_o);

  // R6
  sr_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sr_o) |-> $past(all_idle_i) && (owed_o == '0));

  // R8
  wake_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sr_o) |-> !read_ok_o && !nonread_ok_o);

endmodule

bind dram_refresh_scheduler rfs_checker #(
  .OWED_MAX (OWED_MAX),
  .CW       (CW)
) i_rfs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .all_idle_i   (all_idle_i),
  .iv_tick      (iv_tick),
  .iv_count     (iv_count),
  .ack_acc      (ack_acc),
  .ref_req_o    (ref_req_o),
  .ref_done_o   (ref_done_o),
  .owed_o       (owed_o),
  .in_sr_o      (in_sr_o),
  .nonread_ok_o (nonread_ok_o),
  .read_ok_o    (read_ok_o)
);

// File: tb/test_dram_refresh_scheduler.sv
`timescale 1ns/1ps
module test_dram_refresh_scheduler;

  // Bench settings: 8 ns clock, 100-cycle interval, 10-cycle windows.
  localparam int unsigned CLK_PS   = 8000;
  localparam int unsigned TREFI_NS = 800;
  localparam int unsigned TRFC_NS  = 75;
  localparam int unsigned TXSNR_NS = 75;
  localparam int unsigned TXSRD_CK = 200;
  localparam int unsigned OWED_MAX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic all_idle_i = 1'b0;
  logic ref_ack_i = 1'b0;
  logic sr_enter_i = 1'b0;
  logic sr_exit_i = 1'b0;
  logic ref_req_o, ref_ok_o, ref_done_o, urgent_o, in_sr_o;
  logic nonread_ok_o, read_ok_o;
  logic [3:0] owed_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  dram_refresh_scheduler #(
    .CLK_PS(CLK_PS), .TREFI_NS(TREFI_NS), .TRFC_NS(TRFC_NS),
    .TXSNR_NS(TXSNR_NS), .TXSRD_CK(TXSRD_CK), .OWED_MAX(OWED_MAX)
  ) i_dram_refresh_scheduler (
    .clk(clk), .rst_n(rst_n), .all_idle_i(all_idle_i), .ref_ack_i(ref_ack_i),
    .sr_enter_i(sr_enter_i), .sr_exit_i(sr_exit_i), .ref_req_o(ref_req_o),
    .ref_ok_o(ref_ok_o), .ref_done_o(ref_done_o), .urgent_o(urgent_o),
    .owed_o(owed_o), .in_sr_o(in_sr_o), .nonread_ok_o(nonread_ok_o),
    .read_ok_o(read_ok_o)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: issue one acknowledge, expect owed-1 after it.
  task automatic send_ack();
    exp_q.push_back(int'(owed_o) - 1);
    ref_ack_i = 1'b1;
    @(negedge clk);
    ref_ack_i = 1'b0;
  endtask

  // Monitor: every done pulse must match a queued expectation (R3).
  always @(negedge clk) begin
    if (rst_n && ref_done_o) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected done pulse", 1, 0);
      end else begin
        check("R3 owed after done", int'(owed_o), exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 owed", int'(owed_o), 0);
    check("R9 req", int'(ref_req_o), 0);
    check("R9 urgent", int'(urgent_o), 0);
    check("R9 in_sr", int'(in_sr_o), 0);
    check("R9 nonread_ok", int'(nonread_ok_o), 1);
    check("R9 read_ok", int'(read_ok_o), 1);
    rst_n = 1'b1;

    // R1 first interval
    wait_to(99);
    check("R1 owed before interval", int'(owed_o), 0);
    wait_to(100);
    check("R1 owed after interval", int'(owed_o), 1);
    check("R2 req raised", int'(ref_req_o), 1);
    check("R2 ok held while banks busy", int'(ref_ok_o), 0);
    all_idle_i = 1'b1;
    #1;
    check("R2 ok when idle", int'(ref_ok_o), 1);
    send_ack();                     // accepted at edge 101
    check("R5 req low in window", int'(ref_req_o), 0);
    check("R5 read blocked", int'(read_ok_o), 0);
    wait_to(110);
    check("R5 nonread still blocked", int'(nonread_ok_o), 0);
    wait_to(111);
    check("R5 nonread reopened", int'(nonread_ok_o), 1);
    check("R5 read reopened", int'(read_ok_o), 1);

    // R4 fill the backlog
    all_idle_i = 1'b0;
    wait_to(899);
    check("R4 owed 7", int'(owed_o), 7);
    check("R4 not urgent at 7", int'(urgent_o), 0);
    wait_to(900);
    check("R4 owed at limit", int'(owed_o), 8);
    check("R4 urgent", int'(urgent_o), 1);
    wait_to(1000);
    check("R4 saturated", int'(owed_o), 8);
    check("R4 still urgent", int'(urgent_o), 1);

    // Drain back to back (R3, R5)
    all_idle_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      while (!ref_ok_o) begin
        @(negedge clk);
        #1;
      end
      send_ack();
      if (k == 0) check("R4 urgent cleared", int'(urgent_o), 0);
    end
    check("R3 drained", int'(owed_o), 0);

    // R3 acknowledge with nothing owed is ignored
    wait_to(1095);
    ref_ack_i = 1'b1;
    @(negedge clk);
    ref_ack_i = 1'b0;
    check("R3 ignored ack owed", int'(owed_o), 0);
    check("R3 ignored ack done", int'(ref_done_o), 0);

    // R6 entry waits for idle banks
    wait_to(1100);
    check("R1 owed after drain interval", int'(owed_o), 1);
    all_idle_i = 1'b0;
    sr_enter_i = 1'b1;
    @(negedge clk);
    check("R6 no entry with open banks", int'(in_sr_o), 0);
    all_idle_i = 1'b1;
    @(negedge clk);
    sr_enter_i = 1'b0;
    check("R6 entered", int'(in_sr_o), 1);
    check("R6 owed cleared", int'(owed_o), 0);
    check("R7 nonread blocked", int'(nonread_ok_o), 0);
    check("R7 read blocked", int'(read_ok_o), 0);

    // R7 frozen across several intervals
    wait_to(1402);
    check("R7 owed stays zero", int'(owed_o), 0);
    sr_exit_i = 1'b1;
    @(negedge clk);                 // wake at edge 1403
    sr_exit_i = 1'b0;
    check("R8 left self refresh", int'(in_sr_o), 0);
    wait_to(1412);
    check("R8 nonread blocked", int'(nonread_ok_o), 0);
    wait_to(1413);
    check("R8 nonread allowed", int'(nonread_ok_o), 1);
    check("R8 read still blocked", int'(read_ok_o), 0);
    wait_to(1500);
    check("R7 interval resumed from frozen point", int'(owed_o), 0);
    wait_to(1501);
    check("R7 first tick after wake", int'(owed_o), 1);
    check("R8 no request during wake", int'(ref_req_o), 0);
    wait_to(1602);
    check("R8 read blocked", int'(read_ok_o), 0);
    wait_to(1603);
    check("R8 read allowed", int'(read_ok_o), 1);
    check("R8 request held", int'(ref_req_o), 0);
    check("R1 owed after two ticks", int'(owed_o), 2);
    wait_to(1604);
    check("R8 request resumed", int'(ref_req_o), 1);

    // R5 entry blocked by the refresh window
    send_ack();                     // accepted at edge 1605
    sr_enter_i = 1'b1;
    wait_to(1615);
    check("R5 entry held in window", int'(in_sr_o), 0);
    wait_to(1616);
    check("R6 entry after window", int'(in_sr_o), 1);
    sr_enter_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end

endmodule